// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block lets a host on a two-wire SMBus read and write a small bank of 8-bit control registers. A fast system clock oversamples SCL and SDA. The slave only ever pulls SDA low and never holds SCL. After a start condition it compares the first byte with its own 7-bit address. The byte after that is a command byte that picks the access style. With bit 7 clear, the access is a block transfer that always begins at register 0. With bit 7 set, the access is an indexed byte or word transfer at the offset held in bits 6:0.

To write, the host sends data bytes after the command. A block write puts a byte-count byte before its data. To read, the host sends the command, then a repeated start, then the address with the read bit set. The slave then shifts out register contents, most-significant bit first, until the host answers a byte with NACK. Every register value is presented at all times on a flat output vector. Register k sits in bits 8k+7 down to 8k.

Top module: `smb_cfg_slave`

## Requirements
- R1: A first byte whose upper seven bits equal SLAVE_ADDR is acknowledged. Any other first byte gets no acknowledge: SDA stays released and no register changes until the next start or stop.
- R2: A command byte with bit 7 = 1 selects an indexed access. Bits 6:0 give the offset, and the single data byte that follows is stored at that offset.
- R3: In an indexed write with two data bytes, the first (low) byte lands at the offset and the second (high) byte lands at offset + 1.
- R4: A command byte of 0x00 selects block mode. The byte-count byte and every data byte that follow are acknowledged, and the data bytes are stored at registers 0, 1, 2 and so on in arrival order.
- R5: If a block write is stopped early, every register written before the stop keeps its new value. Registers past the last byte sent keep their previous value.
- R6: An indexed read (command, repeated start, address with read bit set) returns the register at the command offset.
- R7: An indexed read that continues past its first byte returns the register at offset + 1 as the second byte.
- R8: A block read returns first a byte-count byte equal to NREG (8), then registers 0, 1, 2 and so on. The slave stops sending when the host NACKs a byte.
- R9: Offsets at or above NREG are acknowledged on write, but the data is discarded. Reads from such offsets return 0x00.
- R10: After reset the registers hold these values: register 0 = 0x04, register 1 = 0x0F, register 2 = 0xFF, and every other register = 0x00.
- R11: The slave changes its SDA drive only while the synchronised SCL is low. Bytes are shifted most-significant bit first in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_oe | output | 1 | 1 = pull SDA low; 0 = release it |
| regs_o | output | NREG*8 | All register contents; register k at bits 8k+7:8k |

## Verification
The main function is tried under several input patterns. Indexed single-byte and two-byte writes show whether the offset from the command byte is honoured, apart from the pointer auto-increment. Block writes cut short at random lengths separate "store as it arrives" from "store only on completion". Reads of varying length, in both modes, show whether the count byte is inserted and whether the pointer moves only on data bytes. Offsets 7 to 9 and a wrong slave address probe the edge of the bank and address filtering, and every transaction is followed by a compare of the full register vector.

// File: rtl/smb_cfg_pkg.sv
// Shared types and reset values for the two-wire configuration slave.
// Assumes 8-bit registers; the reset table is computed, not stored.
package smb_cfg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed: wait for start
        ST_RX,     // shifting in a byte from the host
        ST_HOLD,   // waiting for SCL fall that begins the next byte
        ST_TX,     // shifting a byte out to the host
        ST_MACK    // host acknowledge slot after a sent byte
    } link_state_t;

    typedef enum logic [1:0] {
        RL_ADDR,
        RL_CMD,
        RL_CNT,
        RL_DATA
    } rx_role_t;

    // Reset value of register idx.
    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h04;
            1:       return 8'h0F;
            2:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_pin_sync.sv
// Synchronises the bus lines into clk and flags SCL edges and the start
// and stop conditions. Assumes each line change is held for several clk
// cycles, so SCL and SDA changes keep their order after the same delay.
module smb_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_q, sda_q;
    logic                   scl_d, sda_d;

    // Synchroniser chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
            sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
            scl_d <= scl_q[SYNC_STAGES-1];
            sda_d <= sda_q[SYNC_STAGES-1];
        end
    end

    // Edge and condition decode on the synchronised lines.
    always_comb begin
        scl_s     = scl_q[SYNC_STAGES-1];
        sda_s     = sda_q[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/smb_reg_bank.sv
// Bank of NREG byte registers with one write port and one read port.
// Addresses at or above NREG: writes dropped, reads give zero.
module smb_reg_bank
    import smb_cfg_pkg::*;
#(
    parameter int NREG = 8,
    parameter int PW   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PW-1:0]        wr_addr,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic [PW-1:0]        rd_addr,
    output logic [BYTE_W-1:0]    rd_data,
    output logic [NREG*BYTE_W-1:0] regs_o
);
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [PW-1:0] LIMIT = PW'(NREG);

    logic [BYTE_W-1:0] mem [NREG];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            // One register: reset to its table value, load on addressed write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[g] <= reg_default(g);
                else if (wr_en && wr_addr == PW'(g))
                    mem[g] <= wr_data;
            end
            assign regs_o[g*BYTE_W +: BYTE_W] = mem[g];
        end
    endgenerate

    // Read mux with zero for offsets beyond the bank.
    always_comb begin
        rd_data = '0;
        if (rd_addr < LIMIT)
            rd_data = mem[rd_addr[IW-1:0]];
    end

endmodule

// File: rtl/smb_link.sv
// Byte-level protocol engine: address filter, command decode, pointer
// handling, acknowledge generation and read shifting. Assumes the bus
// lines arrive synchronised with single-cycle edge and condition flags.
module smb_link
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h52,
    parameter int         NREG       = 8,
    parameter int         PW         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [PW-1:0]     rd_addr,
    output logic              wr_en,
    output logic [PW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe,
    output logic              idle_o
);
    link_state_t       state;
    rx_role_t          role;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              acking, txmode, blk, cnt_pend;
    logic [PW-1:0]     ptr;
    logic [BYTE_W-1:0] rx_byte, tx_byte;

    // Byte being completed and next byte to send.
    always_comb begin
        rx_byte = {shreg[BYTE_W-2:0], sda_s};
        tx_byte = cnt_pend ? BYTE_W'(NREG) : rd_data;
        rd_addr = ptr;
        idle_o  = (state == ST_IDLE);
    end

    // Protocol sequencer; every SDA drive change happens on an SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            role     <= RL_ADDR;
            bit_cnt  <= '0;
            shreg    <= '0;
            acking   <= 1'b0;
            txmode   <= 1'b0;
            blk      <= 1'b0;
            cnt_pend <= 1'b0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                state   <= ST_RX;
                role    <= RL_ADDR;
                bit_cnt <= '0;
                txmode  <= 1'b0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg   <= rx_byte;
                            bit_cnt <= bit_cnt + 4'd1;
                            if (bit_cnt == 4'd7) begin
                                acking <= 1'b1;
                                case (role)
                                    RL_ADDR: begin
                                        if (rx_byte[7:1] == SLAVE_ADDR) begin
                                            txmode   <= rx_byte[0];
                                            cnt_pend <= rx_byte[0] & blk;
                                            role     <= RL_CMD;
                                        end else begin
                                            acking <= 1'b0;
                                        end
                                    end
                                    RL_CMD: begin
                                        blk  <= ~rx_byte[7];
                                        ptr  <= rx_byte[7] ? PW'(rx_byte[6:0]) : '0;
                                        role <= rx_byte[7] ? RL_DATA : RL_CNT;
                                    end
                                    RL_CNT: role <= RL_DATA;
                                    default: begin
                                        wr_en   <= 1'b1;
                                        wr_addr <= ptr;
                                        wr_data <= rx_byte;
                                        ptr     <= ptr + 1'b1;
                                    end
                                endcase
                            end
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (acking) begin
                                sda_oe <= 1'b1;
                                state  <= ST_HOLD;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_HOLD: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (txmode) begin
                                shreg  <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                                state  <= ST_TX;
                                if (cnt_pend) cnt_pend <= 1'b0;
                                else          ptr      <= ptr + 1'b1;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_MACK;
                            end else begin
                                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe  <= ~shreg[BYTE_W-2];
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise)
                            state <= sda_s ? ST_IDLE : ST_HOLD;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/smb_cfg_slave.sv
// Top of the two-wire configuration register slave. Assumes clk is at
// least about eight times faster than SCL; the pad drives SDA low while
// sda_oe is 1.
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h52,
    parameter int         NREG        = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic [NREG*BYTE_W-1:0] regs_o
);
    localparam int PW = 8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en, link_idle;
    logic [PW-1:0]     wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    smb_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_link #(.SLAVE_ADDR(SLAVE_ADDR), .NREG(NREG), .PW(PW)) u_link (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe), .idle_o(link_idle)
    );

    smb_reg_bank #(.NREG(NREG), .PW(PW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .regs_o(regs_o)
    );

endmodule

// File: rtl/smb_cfg_checker.sv
// Protocol and register-bank properties, bound into the top module.
// Assumes the write strobe from the link feeds the bank directly.
module smb_cfg_checker
    import smb_cfg_pkg::*;
#(
    parameter int NREG = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_s,
    input logic                   sda_oe,
    input logic                   link_idle,
    input logic                   wr_en,
    input logic [7:0]             wr_addr,
    input logic [7:0]             wr_data,
    input logic [NREG*BYTE_W-1:0] regs_o
);
    localparam logic [7:0] LIMIT = 8'(NREG);

    function automatic logic [NREG*BYTE_W-1:0] defaults_vec();
        logic [NREG*BYTE_W-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*BYTE_W +: BYTE_W] = reg_default(i);
        return v;
    endfunction

    function automatic logic [7:0] byte_at(input logic [NREG*BYTE_W-1:0] v,
                                           input logic [7:0] idx);
        logic [7:0] r;
        r = '0;
        for (int i = 0; i < NREG; i++)
            if (idx == 8'(i)) r = v[i*BYTE_W +: BYTE_W];
        return r;
    endfunction

    // R10: the first cycle out of reset shows the reset table.
    assert_reset_defaults_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> regs_o == defaults_vec());

    // R11: the SDA drive only moves while SCL is low.
    assert_sda_moves_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // R1: an unaddressed slave never pulls the line.
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        link_idle |-> !sda_oe);

    // R2: an in-range write strobe shows up in the register vector.
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr < LIMIT) |=> byte_at(regs_o, $past(wr_addr)) == $past(wr_data));

    // R9: an out-of-range write strobe changes nothing.
    assert_oor_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= LIMIT) |=> $stable(regs_o));

endmodule

bind smb_cfg_slave smb_cfg_checker #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .link_idle(link_idle), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_o(regs_o)
);

// File: tb/tb_smb_cfg_slave.sv
// Bit-banged host driving the slave; a bench model of the bank predicts
// every read byte and the full register vector.
module tb_smb_cfg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;            // clk cycles per quarter SCL period
    localparam logic [6:0] SADDR = 7'h52;

    logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, bus_sda;
    logic [63:0] regs;
    logic [7:0] mdl [8];
    int n_chk = 0, n_fail = 0;

    assign bus_sda = m_sda & ~sda_oe;
    always #(CLK_PERIOD/2) clk = ~clk;

    smb_cfg_slave #(.SLAVE_ADDR(SADDR)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
        .sda_oe(sda_oe), .regs_o(regs)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_vec();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = mdl[i];
        return v;
    endfunction

    function automatic logic [7:0] exp_at(input int idx);
        return (idx < 8) ? mdl[idx] : 8'h00;
    endfunction

    task automatic tick(input int n); repeat (n) @(negedge clk); endtask

    task automatic clk_bit(input logic v, output logic s);
        tick(Q); m_sda = v; tick(Q); m_scl = 1'b1; tick(Q); s = bus_sda; tick(Q); m_scl = 1'b0;
    endtask

    task automatic bus_start;
        tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0;
    endtask

    task automatic bus_restart;
        tick(Q); m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0;
    endtask

    task automatic bus_stop;
        tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);   // MSB first (R11)
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
        clk_bit(~host_ack, s);
    endtask

    // Indexed write of n (1 or 2) bytes at offset off.
    task automatic wr_index(input int off, input int n, input logic [7:0] d0, input logic [7:0] d1);
        logic a;
        bus_start;
        send_byte({SADDR, 1'b0}, a); check("R1 addr ack", a, 1);
        send_byte({1'b1, 7'(off)}, a); check("R2 cmd ack", a, 1);
        send_byte(d0, a); check("R9 data ack", a, 1);
        if (off < 8) mdl[off] = d0;
        if (n > 1) begin
            send_byte(d1, a); check("R3 high ack", a, 1);
            if (off + 1 < 8) mdl[off+1] = d1;
        end
        bus_stop;
        check(n > 1 ? "R3 word write" : "R2 byte write", regs, model_vec());
    endtask

    // Block write sending n data bytes with count byte cnt.
    task automatic wr_block(input int n, input int cnt);
        logic a;
        logic [7:0] d;
        bus_start;
        send_byte({SADDR, 1'b0}, a); check("R1 addr ack", a, 1);
        send_byte(8'h00, a); check("R4 cmd ack", a, 1);
        send_byte(8'(cnt), a); check("R4 count ack", a, 1);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, a); check("R4 data ack", a, 1);
            mdl[k] = d;
        end
        bus_stop;
        check(n < 8 ? "R5 partial block" : "R4 block write", regs, model_vec());
    endtask

    // Indexed read of n bytes from offset off.
    task automatic rd_index(input int off, input int n);
        logic a;
        logic [7:0] b;
        bus_start;
        send_byte({SADDR, 1'b0}, a); check("R1 addr ack", a, 1);
        send_byte({1'b1, 7'(off)}, a); check("R6 cmd ack", a, 1);
        bus_restart;
        send_byte({SADDR, 1'b1}, a); check("R6 read addr ack", a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n-1, b);
            check(k == 0 ? "R6 byte read" : "R7 word high read", b, exp_at(off + k));
        end
        bus_stop;
    endtask

    // Block read of count byte plus n registers.
    task automatic rd_block(input int n);
        logic a;
        logic [7:0] b;
        bus_start;
        send_byte({SADDR, 1'b0}, a); check("R1 addr ack", a, 1);
        send_byte(8'h00, a); check("R8 cmd ack", a, 1);
        bus_restart;
        send_byte({SADDR, 1'b1}, a); check("R8 read addr ack", a, 1);
        recv_byte(1'b1, b); check("R8 count byte", b, 8);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n-1, b);
            check("R8 block data", b, exp_at(k));
        end
        bus_stop;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic a;
        void'($urandom(32'h5EED1234));
        mdl[0] = 8'h04; mdl[1] = 8'h0F; mdl[2] = 8'hFF;
        for (int i = 3; i < 8; i++) mdl[i] = 8'h00;
        tick(5); rst_n = 1'b1; tick(2);
        check("R10 reset values", regs, 64'h0000_0000_00FF_0F04);
        check("R11 released after reset", sda_oe, 0);

        // Wrong address: no ack, bytes ignored (R1)
        bus_start;
        send_byte({SADDR ^ 7'h01, 1'b0}, a); check("R1 mismatch nack", a, 0);
        send_byte(8'h83, a); check("R1 ignored cmd", a, 0);
        send_byte(8'h5A, a); check("R1 ignored data", a, 0);
        bus_stop;
        check("R1 regs unchanged", regs, model_vec());

        wr_index(3, 1, 8'hA5, 8'h00);        // R2
        rd_index(3, 1);                      // R6
        wr_index(5, 2, 8'h3C, 8'hC3);        // R3
        rd_index(5, 2);                      // R7
        wr_index(7, 2, 8'h81, 8'h7E);        // R3/R9 high byte beyond bank
        wr_index(9, 1, 8'hEE, 8'h00);        // R9 discard
        rd_index(8, 1);                      // R9 read zero
        rd_index(7, 2);                      // R9 high byte zero
        wr_block(8, 8);                      // R4
        rd_block(8);                         // R8
        wr_block(3, 8);                      // R5 early stop
        rd_block(2);                         // R8 short

        for (int it = 0; it < 30; it++) begin
            int op, off, n;
            op  = int'($urandom_range(0, 5));
            off = int'($urandom_range(0, 9));
            n   = int'($urandom_range(1, 8));
            case (op)
                0: wr_index(off, 1, 8'($urandom), 8'h00);
                1: wr_index(off, 2, 8'($urandom), 8'($urandom));
                2: wr_block(n, n);
                3: rd_index(off, 1);
                4: rd_index(off, 2);
                default: rd_block(n);
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule